// File: doc/BRIEF.md
# Receive Frame Length Checker

This block watches the byte stream of a received Ethernet frame, delimited by a start marker on the first byte and an end marker on the last, and counts its length from the destination address through the FCS. The preamble and delimiter are not part of the stream. When a frame closes, the block reports its final length for one cycle, together with flags for too short and too long and a decision on whether the frame is kept or dropped.

Two configuration inputs set the verdict for each port. One enables tagged-frame awareness, which raises the legal ceiling by four bytes. The other lets frames above the legal ceiling be forwarded. A fixed hard cap on buffer size applies whatever the configuration. A frame that grows past the cap without ending is cut off at once. The block then raises an abort pulse and reports the frame as dropped.

Top module: `rx_len_check`

## Requirements
- R1: While reset is held and in the first cycle after it, `stat_valid` and `trunc_abort` are low.
- R2: A frame is every valid byte from the beat carrying `in_sof` through the beat carrying `in_eof`, both included; a single beat with both markers is a one-byte frame. One cycle after the end beat, `stat_valid` is high for exactly one cycle and `stat_len` holds the byte count.
- R3: A frame shorter than 64 bytes sets `stat_runt` and `stat_drop`, whatever the configuration.
- R4: With `cfg_tag_aware` low, frames of 64 to 1518 bytes are reported with `stat_big`, `stat_runt` and `stat_drop` all low, and frames of 1519 bytes or more set `stat_big`.
- R5: With `cfg_tag_aware` high, the legal maximum is 1522 bytes: 1522 is kept, and 1523 sets `stat_big`.
- R6: A frame that sets `stat_big` but stays within 1536 bytes is dropped when `cfg_pass_big` is low and kept when it is high.
- R7: When a frame reaches its 1536th byte without an end marker, then one cycle later `trunc_abort` and `stat_valid` pulse together, with `stat_len` = 1536 and `stat_big` and `stat_drop` set, whatever the configuration. The rest of that frame, up to and including its end beat, produces no further status.
- R8: Cycles with `in_valid` low are not counted. Valid beats outside a frame (no `in_sof` and no frame open) are ignored and produce no status.
- R9: A start marker that arrives while a frame is open restarts the count at one. The unfinished frame produces no status.
- R10: Both configuration inputs are sampled on the end beat, so a change on that beat applies to the frame that is closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pass_big | input | 1 | Keep frames above the legal maximum (up to the hard cap) |
| cfg_tag_aware | input | 1 | Raise the legal maximum to 1522 bytes |
| in_valid | input | 1 | A received byte is present this cycle |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| stat_valid | output | 1 | Status fields are valid this cycle |
| stat_len | output | 11 | Final frame length in bytes |
| stat_runt | output | 1 | Frame shorter than 64 bytes |
| stat_big | output | 1 | Frame above the legal maximum or cut at the cap |
| stat_drop | output | 1 | Frame is to be discarded |
| trunc_abort | output | 1 | Frame cut off at the hard cap |

## Verification
On every cycle, the assertions check these relations between the status fields and the configuration: a runt is always dropped, a legal-length frame is never dropped, a reported length is never zero and never above the cap, and an abort always comes with a full dropped status. They also check that an idle cycle is never followed by status, that the four-byte tagged window follows the sampled awareness bit, and that an oversize verdict follows the sampled forwarding bit. The exact lengths at each boundary (63/64, 1518/1519, 1522/1523, 1536 with and without an end marker) are shown only by the bench's scenarios. The same holds for the silence after a cut-off frame, the restart on an early start marker and a configuration change that lands on the end beat.

// File: rtl/rx_len_check.sv
module rx_len_check #(
  parameter int MIN_LEN  = 64,
  parameter int STD_MAX  = 1518,
  parameter int TAG_MAX  = 1522,
  parameter int HARD_CAP = 1536,
  localparam int LEN_W   = $clog2(HARD_CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pass_big,
  input  logic             cfg_tag_aware,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             stat_valid,
  output logic [LEN_W-1:0] stat_len,
  output logic             stat_runt,
  output logic             stat_big,
  output logic             stat_drop,
  output logic             trunc_abort
);

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] STD_L = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] TAG_L = LEN_W'(TAG_MAX);
  localparam logic [LEN_W-1:0] CAP_L = LEN_W'(HARD_CAP);

  logic [LEN_W-1:0] cnt, nxt, lmax;
  logic busy, beat, done, cap_hit, runt_c, big_c;

  assign beat    = in_valid & (in_sof | busy);
  assign nxt     = in_sof ? LEN_W'(1) : cnt + 1'b1;
  assign done    = beat & in_eof;
  assign cap_hit = beat & ~in_eof & (nxt == CAP_L);
  assign lmax    = cfg_tag_aware ? TAG_L : STD_L;
  assign runt_c  = nxt < MIN_L;
  assign big_c   = nxt > lmax;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      busy        <= 1'b0;
      stat_valid  <= 1'b0;
      stat_len    <= '0;
      stat_runt   <= 1'b0;
      stat_big    <= 1'b0;
      stat_drop   <= 1'b0;
      trunc_abort <= 1'b0;
    end else begin
      stat_valid  <= done | cap_hit;
      trunc_abort <= cap_hit;
      if (beat) cnt <= nxt;
      if (done | cap_hit)    busy <= 1'b0;
      else if (in_valid & in_sof) busy <= 1'b1;
      if (done | cap_hit) begin
        stat_len  <= nxt;
        stat_runt <= done & runt_c;
        stat_big  <= cap_hit | big_c;
        stat_drop <= cap_hit | runt_c | (big_c & ~cfg_pass_big);
      end
    end
  end

endmodule

// File: rtl/rx_len_check_props.sv
module rx_len_check_props #(
  parameter int MIN_LEN  = 64,
  parameter int STD_MAX  = 1518,
  parameter int TAG_MAX  = 1522,
  parameter int HARD_CAP = 1536,
  localparam int LEN_W   = $clog2(HARD_CAP + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_pass_big,
  input logic             cfg_tag_aware,
  input logic             in_valid,
  input logic             stat_valid,
  input logic [LEN_W-1:0] stat_len,
  input logic             stat_runt,
  input logic             stat_big,
  input logic             stat_drop,
  input logic             trunc_abort
);

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] STD_L = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] TAG_L = LEN_W'(TAG_MAX);
  localparam logic [LEN_W-1:0] CAP_L = LEN_W'(HARD_CAP);

  p_runt_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && stat_runt |-> stat_drop);

  p_legal_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !stat_runt && !stat_big |-> !stat_drop && stat_len >= MIN_L);

  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> stat_len != '0 && stat_len <= CAP_L);

  p_abort_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_abort |-> stat_valid && stat_drop && stat_big && stat_len == CAP_L);

  p_tag_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !trunc_abort && stat_len > STD_L && stat_len <= TAG_L
      |-> stat_big == !$past(cfg_tag_aware));

  p_pass_big_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !trunc_abort && stat_big |-> stat_drop == !$past(cfg_pass_big));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !stat_valid);

endmodule

bind rx_len_check rx_len_check_props #(
  .MIN_LEN(MIN_LEN), .STD_MAX(STD_MAX), .TAG_MAX(TAG_MAX), .HARD_CAP(HARD_CAP)
) u_props (.*);

// File: tb/test_rx_len_check.sv
module test_rx_len_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pass_big = 1'b0, cfg_tag_aware = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic stat_valid, stat_runt, stat_big, stat_drop, trunc_abort;
  logic [10:0] stat_len;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  rx_len_check i_rx_len_check (.*);

  // behavioural reference model
  int  m_cnt = 0;
  bit  m_open = 0;
  bit  e_sv = 0, e_ab = 0, e_runt = 0, e_big = 0, e_drop = 0;
  int  e_len = 0;

  always @(posedge clk) begin
    e_sv = 0; e_ab = 0;
    if (!rst_n) begin
      m_cnt = 0; m_open = 0;
    end else if (in_valid) begin
      if (in_sof) begin m_cnt = 1; m_open = 1; end
      else if (m_open) m_cnt = m_cnt + 1;
      if (m_open) begin
        if (in_eof) begin
          int lim;
          lim = cfg_tag_aware ? 1522 : 1518;
          e_sv = 1; e_len = m_cnt; e_runt = m_cnt < 64; e_big = m_cnt > lim;
          e_drop = e_runt || (e_big && !cfg_pass_big);
          m_open = 0;
        end else if (m_cnt == 1536) begin
          e_sv = 1; e_ab = 1; e_len = 1536; e_runt = 0; e_big = 1; e_drop = 1;
          m_open = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    bit bad;
    bad = 0;
    checks++;
    if (trunc_abort !== e_ab) begin
      bad = 1; $display("FAIL %s trunc_abort got %b exp %b", cur_req, trunc_abort, e_ab);
    end
    if (stat_valid !== e_sv) begin
      bad = 1; $display("FAIL %s stat_valid got %b exp %b", cur_req, stat_valid, e_sv);
    end else if (e_sv) begin
      if (stat_len !== 11'(e_len)) begin
        bad = 1; $display("FAIL %s stat_len got %0d exp %0d", cur_req, stat_len, e_len);
      end
      if (stat_runt !== e_runt) begin
        bad = 1; $display("FAIL %s stat_runt got %b exp %b", cur_req, stat_runt, e_runt);
      end
      if (stat_big !== e_big) begin
        bad = 1; $display("FAIL %s stat_big got %b exp %b", cur_req, stat_big, e_big);
      end
      if (stat_drop !== e_drop) begin
        bad = 1; $display("FAIL %s stat_drop got %b exp %b", cur_req, stat_drop, e_drop);
      end
    end
    if (bad) errors++;
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0;
    end
  endtask

  task automatic stray(bit with_eof);
    @(negedge clk); in_valid = 1; in_sof = 0; in_eof = with_eof;
  endtask

  // n bytes; close=0 leaves the frame open; gap>0 inserts a valid-low cycle before byte gap
  task automatic frame(int n, bit close = 1, int gap = 0, bit flip = 0);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i == gap) idle(1);
      @(negedge clk);
      if (flip && close && i == n - 1) begin
        cfg_tag_aware = ~cfg_tag_aware; cfg_pass_big = ~cfg_pass_big;
      end
      in_valid = 1; in_sof = (i == 0); in_eof = close && (i == n - 1);
    end
    if (flip && close) begin
      @(negedge clk);
      cfg_tag_aware = ~cfg_tag_aware; cfg_pass_big = ~cfg_pass_big;
      in_valid = 0; in_sof = 0; in_eof = 0;
    end
  endtask

  initial begin
    cur_req = "R1";
    idle(5);
    @(negedge clk); rst_n = 1;
    idle(3);

    cur_req = "R2";
    frame(64); idle(2);
    frame(100, 1, 7); idle(1);
    frame(1); frame(1); frame(65); idle(3);

    cur_req = "R8";
    stray(0); stray(1); stray(0); idle(1);
    frame(80, 1, 40); stray(1); stray(0); idle(2);

    cur_req = "R3";
    frame(63); idle(1); frame(10); idle(1);
    cfg_pass_big = 1; cfg_tag_aware = 1; frame(2); idle(2);
    cfg_pass_big = 0; cfg_tag_aware = 0;

    cur_req = "R4";
    frame(1518); idle(2); frame(1519); idle(2);

    cur_req = "R5";
    cfg_tag_aware = 1;
    frame(1522); idle(2); frame(1523); idle(2); frame(1519); idle(2);

    cur_req = "R6";
    cfg_pass_big = 1;
    frame(1530); idle(2); frame(1536); idle(2);
    cfg_tag_aware = 0; frame(1520); idle(2);
    cfg_pass_big = 0; frame(1536); idle(2);

    cur_req = "R7";
    cfg_pass_big = 1; cfg_tag_aware = 1;
    frame(1600); idle(3);
    frame(1537); idle(2);
    frame(1536, 0); stray(0); stray(1); idle(3);

    cur_req = "R9";
    frame(500, 0); frame(70); idle(2);
    frame(30, 0); frame(1537); idle(2);

    cur_req = "R10";
    cfg_pass_big = 0; cfg_tag_aware = 0;
    frame(1520, 1, 0, 1); idle(2);
    frame(1530, 1, 0, 1); idle(2);

    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog expired got running exp finished", cur_req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule